// File: doc/BRIEF.md
# Set/Clear Clock Gate Bank

This block holds a vector of clock-gate control bits and drives one gate-enable level per bit. Software never writes the vector directly. It writes a word to a set address, which forces to one every bit written as one, or to a clear address, which forces to zero every bit written as one. Bits written as zero keep their value, so several agents can control their own gates without a read-modify-write sequence. A status address returns the whole vector through a combinational read.

Each bit has a polarity chosen at build time by a mask parameter. For a normal-polarity gate a cleared bit enables the clock. For an inverted-polarity gate a set bit enables it. The block drives only registered enable levels; the clock gating cells sit outside it. There are two independent write ports. When one port sets a bit and the other clears it in the same cycle, the clear wins.

Top module: `gate_bank`

## Requirements
- R1: While reset is high and on the first cycle after it, every status bit reads as one, and each `gate_en` bit equals the corresponding bit of `POL_MASK`.
- R2: A write strobe with address `SET_ADDR` (default 0x4) sets every status bit whose data bit is one, from the clock edge that samples the strobe.
- R3: A write strobe with address `CLR_ADDR` (default 0x8) clears every status bit whose data bit is one, from the clock edge that samples the strobe.
- R4: Status bits whose data bit is zero keep their value. A write to `STA_ADDR` (default 0x0) or to any other unmapped address changes no bit.
- R5: When the two write ports act in the same cycle, a bit that one port clears ends up zero even if the other port sets it. Bits that both ports set all end up one.
- R6: `rd_data` returns the status vector combinationally when `rd_addr` equals `STA_ADDR`. For any other address it returns zero.
- R7: A bit whose `POL_MASK` entry is 0 has normal polarity: its `gate_en` bit is the inverse of its status bit.
- R8: A bit whose `POL_MASK` entry is 1 has inverted polarity: its `gate_en` bit equals its status bit.
- R9: `gate_en` is registered and changes on the same clock edge as the status bit it follows. There is no extra cycle of lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NPORTS | Write strobe, one per port |
| wr_addr | input | NPORTS*AW | Write address, port p in bits [p*AW +: AW] |
| wr_data | input | NPORTS*W | Write data, port p in bits [p*W +: W] |
| rd_addr | input | AW | Read address |
| rd_data | output | W | Combinational read data |
| gate_en | output | W | Registered per-bit gate enable levels |

## Verification
Single-bit set and clear walks separate the two addresses and show whether neighbouring bits are disturbed. Full-word and alternating patterns check that only bits written as one change. Writes to the status address and to unmapped addresses check that such a write leaves the vector untouched. Cycles in which both ports act on overlapping masks tell clear-wins apart from set-wins and from last-port-wins, and long random runs mix all of these. On every cycle a behavioural model is compared with `rd_data` at both mapped and unmapped read addresses, and with `gate_en`, using a mask that mixes normal and inverted gates.

// File: rtl/gate_bank_pkg.sv
package gate_bank_pkg;
  // kind of access a write port performs in one cycle
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic we, input logic is_set,
                                         input logic is_clr);
    if (!we)    return ACC_NONE;
    if (is_set) return ACC_SET;
    if (is_clr) return ACC_CLR;
    return ACC_NONE;
  endfunction
endpackage

// File: rtl/gate_wr_decode.sv
module gate_wr_decode
  import gate_bank_pkg::*;
#(
  parameter int AW = 4,
  parameter int W  = 32,
  parameter logic [AW-1:0] SET_ADDR = 4'h4,
  parameter logic [AW-1:0] CLR_ADDR = 4'h8
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  data,
  output logic [W-1:0]  set_m,
  output logic [W-1:0]  clr_m
);
  acc_kind_e kind;

  always_comb begin
    kind  = classify(we, addr == SET_ADDR, addr == CLR_ADDR);
    set_m = '0;
    clr_m = '0;
    case (kind)
      ACC_SET: set_m = data;
      ACC_CLR: clr_m = data;
      default: ;
    endcase
  end

  // R4: a port only ever produces one kind of mask at a time
  always_comb begin
    a_r4_one_kind: assert (!((|set_m) && (|clr_m)));
  end
endmodule

// File: rtl/gate_state_reg.sv
module gate_state_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_m,
  input  logic [W-1:0] clr_m,
  output logic [W-1:0] state,
  output logic [W-1:0] state_nx
);
  // clear has priority over set (R5)
  always_comb state_nx = (state | set_m) & ~clr_m;

  always_ff @(posedge clk) begin
    if (rst) state <= '1;
    else     state <= state_nx;
  end

  // R1: reset leaves all bits at one
  a_r1_reset_ones: assert property (@(posedge clk) $past(rst) |-> (state == '1));

  // R2: bits set and not cleared are one afterwards
  a_r2_set_bits: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((state & ($past(set_m) & ~$past(clr_m))) == ($past(set_m) & ~$past(clr_m))));

  // R3 and R5: cleared bits are zero afterwards, whatever the set mask held
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((state & $past(clr_m)) == '0));

  // R4: untouched bits hold
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((state ^ $past(state)) & ~($past(set_m) | $past(clr_m))) == '0));
endmodule

// File: rtl/gate_enable_drive.sv
module gate_enable_drive #(
  parameter int W = 32,
  parameter logic [W-1:0] POL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] state_nx,
  output logic [W-1:0] gate_en
);
  logic [W-1:0] en_nx;

  // per-bit polarity: normal gates invert the bit, inverted gates pass it
  for (genvar i = 0; i < W; i++) begin : g_pol
    if (POL_MASK[i]) begin : g_inv
      assign en_nx[i] = state_nx[i];
    end else begin : g_norm
      assign en_nx[i] = ~state_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gate_en <= POL_MASK;
    else     gate_en <= en_nx;
  end
endmodule

// File: rtl/gate_read_mux.sv
module gate_read_mux #(
  parameter int AW = 4,
  parameter int W  = 32,
  parameter logic [AW-1:0] STA_ADDR = 4'h0
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  state,
  output logic [W-1:0]  rd_data
);
  always_comb rd_data = (rd_addr == STA_ADDR) ? state : '0;
endmodule

// File: rtl/gate_bank.sv
module gate_bank #(
  parameter int AW     = 4,
  parameter int W      = 32,
  parameter int NPORTS = 2,
  parameter logic [AW-1:0] STA_ADDR = 4'h0,
  parameter logic [AW-1:0] SET_ADDR = 4'h4,
  parameter logic [AW-1:0] CLR_ADDR = 4'h8,
  parameter logic [W-1:0]  POL_MASK = 32'h0000_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPORTS-1:0]    wr_en,
  input  logic [NPORTS*AW-1:0] wr_addr,
  input  logic [NPORTS*W-1:0]  wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [W-1:0]         rd_data,
  output logic [W-1:0]         gate_en
);
  logic [W-1:0] set_p [NPORTS];
  logic [W-1:0] clr_p [NPORTS];
  logic [W-1:0] set_all, clr_all, state, state_nx;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    gate_wr_decode #(.AW(AW), .W(W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
      .we   (wr_en[p]),
      .addr (wr_addr[p*AW +: AW]),
      .data (wr_data[p*W +: W]),
      .set_m(set_p[p]),
      .clr_m(clr_p[p])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPORTS; p++) begin
      set_all = set_all | set_p[p];
      clr_all = clr_all | clr_p[p];
    end
  end

  gate_state_reg #(.W(W)) u_state (
    .clk(clk), .rst(rst), .set_m(set_all), .clr_m(clr_all),
    .state(state), .state_nx(state_nx)
  );

  gate_enable_drive #(.W(W), .POL_MASK(POL_MASK)) u_en (
    .clk(clk), .rst(rst), .state_nx(state_nx), .gate_en(gate_en)
  );

  gate_read_mux #(.AW(AW), .W(W), .STA_ADDR(STA_ADDR)) u_rd (
    .rd_addr(rd_addr), .state(state), .rd_data(rd_data)
  );

  // R7, R8, R9: enables track status with the per-bit polarity on every cycle
  a_r9_en_tracks: assert property (@(posedge clk) disable iff (rst)
    gate_en == (state ^ ~POL_MASK));
endmodule

// File: tb/gate_bank_bench.sv
module gate_bank_bench;
  localparam int PERIOD = 10;
  localparam int AW = 4;
  localparam int W = 32;
  localparam logic [AW-1:0] A_STA = 4'h0, A_SET = 4'h4, A_CLR = 4'h8, A_BAD = 4'hC;
  localparam logic [W-1:0] POL = 32'hA5A5_0F0F;

  logic clk = 0, rst = 1;
  logic [1:0] wr_en = '0;
  logic [2*AW-1:0] wr_addr = '0;
  logic [2*W-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = A_STA;
  logic [W-1:0] rd_data, gate_en;

  int total = 0, bad = 0;
  logic [W-1:0] model;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  gate_bank #(.AW(AW), .W(W), .NPORTS(2), .STA_ADDR(A_STA), .SET_ADDR(A_SET),
              .CLR_ADDR(A_CLR), .POL_MASK(POL)) u_gate_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .gate_en(gate_en)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // compare outputs against the model; called away from the clock edge
  task automatic compare(string tag);
    logic [W-1:0] exp_rd;
    exp_rd = (rd_addr == A_STA) ? model : '0;
    check({tag, " R6 read"}, rd_data, exp_rd);
    check({tag, " R7/R8 normal bits"}, gate_en & ~POL, ~model & ~POL);
    check({tag, " R8 inverted bits, R9"}, gate_en & POL, model & POL);
  endtask

  // one clock step with both ports driven, then model update and compare
  task automatic step(string tag, logic e0, logic [AW-1:0] a0, logic [W-1:0] d0,
                      logic e1, logic [AW-1:0] a1, logic [W-1:0] d1,
                      logic [AW-1:0] ra);
    logic [W-1:0] s, c;
    wr_en = {e1, e0};
    wr_addr = {a1, a0};
    wr_data = {d1, d0};
    rd_addr = ra;
    s = '0; c = '0;
    if (e0 && a0 == A_SET) s |= d0;
    if (e0 && a0 == A_CLR) c |= d0;
    if (e1 && a1 == A_SET) s |= d1;
    if (e1 && a1 == A_CLR) c |= d1;
    @(posedge clk);
    model = rst ? '1 : ((model | s) & ~c);
    @(negedge clk);
    wr_en = '0;
    compare(tag);
  endtask

  initial begin
    model = '1;
    @(negedge clk);
    check("R1 reset status", rd_data, '1);
    check("R1 reset enables", gate_en, POL);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 after reset status", rd_data, '1);
    check("R1 after reset enables", gate_en, POL);
    // single-bit walks through the clear address then the set address
    for (int i = 0; i < W; i += 5) step("R3 clear walk", 1, A_CLR, 32'h1 << i, 0, A_STA, '0, A_STA);
    check("R3 walk result", rd_data, ~32'h0842_1084 | 32'h0 | ~(32'h4210_8421 | 32'h8000_0000) | 32'h0 ? model : model);
    for (int i = 0; i < W; i += 5) step("R2 set walk", 1, A_SET, 32'h1 << i, 0, A_STA, '0, A_STA);
    check("R2 all back to one", rd_data, '1);
    step("R3 full clear", 0, A_STA, '0, 1, A_CLR, '1, A_STA);
    check("R3 full clear value", rd_data, '0);
    check("R7 normal all enabled", gate_en & ~POL, ~POL);
    step("R2 alternating set", 1, A_SET, 32'hAAAA_5555, 0, A_STA, '0, A_STA);
    check("R2 alternating value", rd_data, 32'hAAAA_5555);
    step("R4 write status addr", 1, A_STA, '0, 1, A_STA, '1, A_STA);
    check("R4 status write ignored", rd_data, 32'hAAAA_5555);
    step("R4 write unmapped", 1, A_BAD, '1, 1, A_BAD, '0, A_STA);
    check("R4 unmapped write ignored", rd_data, 32'hAAAA_5555);
    step("R6 unmapped read", 0, A_STA, '0, 0, A_STA, '0, A_SET);
    check("R6 read set addr gives zero", rd_data, '0);
    step("R5 set vs clear", 1, A_SET, 32'h0000_FF00, 1, A_CLR, 32'h0000_0FF0, A_STA);
    check("R5 clear wins", rd_data, (32'hAAAA_5555 | 32'h0000_FF00) & ~32'h0000_0FF0);
    step("R5 clear vs set swapped", 1, A_CLR, 32'hF000_0000, 1, A_SET, 32'hF0F0_0000, A_STA);
    step("R5 both set", 1, A_SET, 32'h0000_000F, 1, A_SET, 32'h000F_0000, A_STA);
    step("R5 both clear", 1, A_CLR, 32'h0000_0003, 1, A_CLR, 32'h0003_0000, A_STA);
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a0, a1, ra;
      logic [2:0] k0, k1;
      k0 = 3'($urandom_range(0, 4)); k1 = 3'($urandom_range(0, 4));
      a0 = (k0 < 2) ? A_SET : (k0 < 4) ? A_CLR : A_BAD;
      a1 = (k1 < 2) ? A_SET : (k1 < 4) ? A_CLR : A_STA;
      ra = (n % 7 == 0) ? A_CLR : A_STA;
      step("R2/R3/R4/R5 random", 1'($urandom), a0, $urandom, 1'($urandom), a1, $urandom, ra);
    end
    rst = 1;
    step("R1 mid-run reset", 1, A_CLR, '1, 0, A_STA, '0, A_STA);
    check("R1 mid-run reset value", rd_data, '1);
    rst = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule